// File: doc/BRIEF.md
# Three-Destination Interrupt Router

The block gathers one-cycle event pulses from a device controller (endpoint events, DMA channel completions, bus error detectors and USB link events) into two sticky status words. Software clears each status bit by writing a one to it through a small register port. The port takes an address, a write strobe and write data, and returns read data combinationally.

The same pair of status words feeds three interrupt outputs: the host bus, a local microcontroller and a USB-side wake path. Each destination has its own enable words and its own master enable in bit 31. The host and microcontroller destinations can see both status groups. The USB destination sees only the system group, so endpoint and setup events can never reach it. Each output is registered. Status word 0 also reports the current level of the host output so that software can read it.

Top module: `irq_router`

Register map (3-bit address): 0 = endpoint status, 1 = system status, 2 = host enable group 0, 3 = host enable group 1, 4 = CPU enable group 0, 5 = CPU enable group 1, 6 = USB enable group 1, 7 = reserved.

## Requirements
- R1: After reset every register reads zero and all three interrupt outputs are low.
- R2: A source pulse on an implemented bit sets that status bit at the next clock edge, and the bit stays set until software clears it.
- R3: A write to address 0 or 1 clears exactly the status bits written as one and leaves every other bit unchanged.
- R4: When a source pulse and a write-one-to-clear hit the same bit in the same cycle, the bit ends set.
- R5: Status word 0 implements bits 7:0: bit 0 is endpoint 0, bits 1-6 are endpoints A-F and bit 7 is setup received. Status word 1 implements bits 0-4, 6-13, 16, 17 and 19-27. All other status bits read zero, whatever pulses or writes arrive.
- R6: Enable words at addresses 2-6 read back the written value. Group-0 enables keep bits 7:0, and group-1 enables keep the implemented status-1 bits plus bit 31. Other bits read zero. Address 7 reads zero.
- R7: The host output goes high one clock after its master bit is set and (status0 AND host-enable0) or (status1 AND host-enable1) is nonzero. It goes low one clock after that condition ends.
- R8: The CPU output follows the same rule using the CPU enable words.
- R9: The USB output follows the same rule using status 1 and the USB enable word only. Status word 0 never drives it.
- R10: Status word 0 bit 12 reads the current host output level, and writes to that bit have no effect.
- R11: While a destination's master bit is clear, its output stays low whatever the status and enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_ep | input | 8 | Endpoint/setup event pulses, one per status-0 bit |
| src_sys | input | 32 | System event pulses, one per status-1 bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| host_irq | output | 1 | Host bus interrupt |
| cpu_irq | output | 1 | Microcontroller interrupt |
| usb_irq | output | 1 | USB wake-path interrupt |

## Verification
The assertions check properties that hold on every cycle. Pulsed bits are captured and kept, and a same-cycle clear never beats a pulse. Status stays stable when nothing acts on it, and reserved status bits stay zero. A cleared master enable, or an empty USB enable word, holds the matching output low. The exact routing needs the bench's reference model, compared every clock. That covers which status/enable combination raises which output, the one-cycle output latency, the read-back of enables and of the host level in status bit 12, and the fact that endpoint events never reach the USB destination.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int EP_W   = 8,
  parameter int DW     = 32,
  parameter int AW     = 3,
  parameter logic [DW-1:0] SYS_MASK = 32'h0FFB_3FDF,
  parameter int HOST_BIT = 12,
  parameter int MASTER_BIT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EP_W-1:0] src_ep,
  input  logic [DW-1:0] src_sys,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          host_irq,
  output logic          cpu_irq,
  output logic          usb_irq
);
  localparam logic [DW-1:0] EN1_MASK = SYS_MASK | (DW'(1) << MASTER_BIT);

  logic [EP_W-1:0] ep_q, hen0_q, cen0_q;
  logic [DW-1:0]   sys_q, hen1_q, cen1_q, uen1_q;

  wire wr_ep  = reg_wr && reg_addr == AW'(0);
  wire wr_sys = reg_wr && reg_addr == AW'(1);

  wire host_req = hen1_q[MASTER_BIT] && (|(ep_q & hen0_q) || |(sys_q & hen1_q & SYS_MASK));
  wire cpu_req  = cen1_q[MASTER_BIT] && (|(ep_q & cen0_q) || |(sys_q & cen1_q & SYS_MASK));
  wire usb_req  = uen1_q[MASTER_BIT] && |(sys_q & uen1_q & SYS_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ep_q <= '0; sys_q <= '0;
      hen0_q <= '0; cen0_q <= '0;
      hen1_q <= '0; cen1_q <= '0; uen1_q <= '0;
      host_irq <= 1'b0; cpu_irq <= 1'b0; usb_irq <= 1'b0;
    end else begin
      ep_q  <= (ep_q & ~(wr_ep ? reg_wdata[EP_W-1:0] : '0)) | src_ep;
      sys_q <= ((sys_q & ~(wr_sys ? reg_wdata : '0)) | src_sys) & SYS_MASK;
      if (reg_wr) begin
        case (reg_addr)
          AW'(2): hen0_q <= reg_wdata[EP_W-1:0];
          AW'(3): hen1_q <= reg_wdata & EN1_MASK;
          AW'(4): cen0_q <= reg_wdata[EP_W-1:0];
          AW'(5): cen1_q <= reg_wdata & EN1_MASK;
          AW'(6): uen1_q <= reg_wdata & EN1_MASK;
          default: ;
        endcase
      end
      host_irq <= host_req;
      cpu_irq  <= cpu_req;
      usb_irq  <= usb_req;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(0): begin
        reg_rdata[EP_W-1:0] = ep_q;
        reg_rdata[HOST_BIT] = host_irq;
      end
      AW'(1): reg_rdata = sys_q;
      AW'(2): reg_rdata[EP_W-1:0] = hen0_q;
      AW'(3): reg_rdata = hen1_q;
      AW'(4): reg_rdata[EP_W-1:0] = cen0_q;
      AW'(5): reg_rdata = cen1_q;
      AW'(6): reg_rdata = uen1_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

module irq_router_chk #(
  parameter int EP_W = 8,
  parameter int DW   = 32,
  parameter int AW   = 3,
  parameter logic [DW-1:0] SYS_MASK = 32'h0FFB_3FDF
) (
  input logic            clk,
  input logic            rst_n,
  input logic [EP_W-1:0] src_ep,
  input logic [DW-1:0]   src_sys,
  input logic            reg_wr,
  input logic [AW-1:0]   reg_addr,
  input logic [EP_W-1:0] ep_q,
  input logic [DW-1:0]   sys_q,
  input logic            host_m,
  input logic            cpu_m,
  input logic            usb_m,
  input logic [DW-1:0]   usb_en,
  input logic            host_irq,
  input logic            cpu_irq,
  input logic            usb_irq
);
  p_ep_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ep != '0) |=> ((ep_q & $past(src_ep)) == $past(src_ep)));

  p_pulse_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(1) && (src_sys & SYS_MASK) != '0)
      |=> ((sys_q & $past(src_sys & SYS_MASK)) == $past(src_sys & SYS_MASK)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && src_ep == '0 && src_sys == '0) |=> ($stable(ep_q) && $stable(sys_q)));

  p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_q & ~SYS_MASK) == '0);

  p_host_master_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !host_m |=> !host_irq);

  p_cpu_master_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_m |=> !cpu_irq);

  p_usb_master_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !usb_m |=> !usb_irq);

  p_usb_sys_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((sys_q & usb_en & SYS_MASK) == '0) |=> !usb_irq);
endmodule

bind irq_router irq_router_chk #(.EP_W(EP_W), .DW(DW), .AW(AW), .SYS_MASK(SYS_MASK)) i_chk (
  .clk(clk), .rst_n(rst_n), .src_ep(src_ep), .src_sys(src_sys),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .ep_q(ep_q), .sys_q(sys_q),
  .host_m(hen1_q[MASTER_BIT]), .cpu_m(cen1_q[MASTER_BIT]), .usb_m(uen1_q[MASTER_BIT]),
  .usb_en(uen1_q), .host_irq(host_irq), .cpu_irq(cpu_irq), .usb_irq(usb_irq)
);

// File: tb/test_irq_router.sv
module test_irq_router;
  localparam logic [31:0] SYSM = 32'h0FFB_3FDF;
  localparam logic [31:0] EN1M = 32'h8FFB_3FDF;

  logic clk = 0, rst_n = 0;
  logic [7:0]  src_ep = '0;
  logic [31:0] src_sys = '0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic host_irq, cpu_irq, usb_irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_router i_irq_router (.*);

  // behavioural reference model
  logic [31:0] m_st0, m_st1, m_en[8];
  logic m_h, m_c, m_u;

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {19'b0, m_h, 4'b0, m_st0[7:0]};
      3'd1: return m_st1;
      3'd7: return 32'b0;
      default: return m_en[a];
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st0 <= 0; m_st1 <= 0; m_h <= 0; m_c <= 0; m_u <= 0;
      for (int i = 0; i < 8; i++) m_en[i] <= 0;
    end else begin
      m_h <= m_en[3][31] && (((m_st0 & m_en[2]) != 0) || ((m_st1 & m_en[3] & SYSM) != 0));
      m_c <= m_en[5][31] && (((m_st0 & m_en[4]) != 0) || ((m_st1 & m_en[5] & SYSM) != 0));
      m_u <= m_en[6][31] && ((m_st1 & m_en[6] & SYSM) != 0);
      m_st0 <= ((m_st0 & ~((reg_wr && reg_addr == 0) ? reg_wdata : 32'b0)) | {24'b0, src_ep}) & 32'hFF;
      m_st1 <= ((m_st1 & ~((reg_wr && reg_addr == 1) ? reg_wdata : 32'b0)) | src_sys) & SYSM;
      if (reg_wr) begin
        if (reg_addr == 2 || reg_addr == 4) m_en[reg_addr] <= reg_wdata & 32'hFF;
        if (reg_addr == 3 || reg_addr == 5 || reg_addr == 6) m_en[reg_addr] <= reg_wdata & EN1M;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(host_irq === m_h, "R7 host_irq", {31'b0, host_irq}, {31'b0, m_h});
      chk(cpu_irq === m_c, "R8 cpu_irq", {31'b0, cpu_irq}, {31'b0, m_c});
      chk(usb_irq === m_u, "R9 usb_irq", {31'b0, usb_irq}, {31'b0, m_u});
      chk(reg_rdata === m_read(reg_addr), "R6 rdata model", reg_rdata, m_read(reg_addr));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic pulse(input logic [7:0] e, input logic [31:0] s);
    @(negedge clk); src_ep = e; src_sys = s;
    @(negedge clk); src_ep = '0; src_sys = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_addr = a; #1;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic out(input logic h, input logic c, input logic u, input string tag);
    chk({host_irq, cpu_irq, usb_irq} === {h, c, u}, tag,
        {29'b0, host_irq, cpu_irq, usb_irq}, {29'b0, h, c, u});
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "watchdog", 0, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), 32'b0, "R1 reset read");
    out(0, 0, 0, "R1 reset outputs");

    // R2 sticky set
    pulse(8'h08, 0);
    rd(0, 32'h08, "R2 set");
    repeat (5) @(negedge clk);
    rd(0, 32'h08, "R2 sticky");

    // R3 W1C only clears ones
    wr(0, 32'h01);
    rd(0, 32'h08, "R3 other bit kept");
    wr(0, 32'h08);
    rd(0, 32'h00, "R3 cleared");

    // R5 implemented bits
    pulse(8'hFF, 32'hFFFF_FFFF);
    rd(0, 32'hFF, "R5 stat0 bits");
    rd(1, SYSM, "R5 stat1 bits");
    wr(1, 32'hFFFF_FFFF);
    wr(0, 32'hFFFF_FFFF);
    rd(1, 32'h0, "R5 stat1 clear");

    // R6 enable readback
    wr(2, 32'hFFFF_FFFF); rd(2, 32'hFF, "R6 hen0");
    wr(3, 32'h7FFF_FFFF); rd(3, SYSM, "R6 hen1");
    wr(6, 32'hFFFF_FFFF); rd(6, EN1M, "R6 uen1");
    wr(7, 32'hFFFF_FFFF); rd(7, 32'h0, "R6 reserved addr");
    wr(2, 0); wr(3, 0); wr(6, 0);

    // R4 pulse vs clear same cycle
    @(negedge clk); src_sys = 32'h1; reg_wr = 1; reg_addr = 1; reg_wdata = 32'h1;
    @(negedge clk); src_sys = 0; reg_wr = 0;
    rd(1, 32'h1, "R4 pulse wins");
    wr(1, 32'h1);

    // R7/R10 host routing from group 0
    wr(2, 32'h08); wr(3, 32'h8000_0000);
    pulse(8'h08, 0);
    @(negedge clk);
    out(1, 0, 0, "R7 host asserted");
    rd(0, 32'h1008, "R10 host level in stat0");
    wr(0, 32'h1000);
    rd(0, 32'h1008, "R10 bit12 ignores writes");
    wr(3, 0);
    @(negedge clk);
    out(0, 0, 0, "R11 host master off");
    wr(0, 32'hFF);

    // R8 cpu routing from group 1
    wr(5, 32'h8000_0200);
    pulse(0, 32'h200);
    @(negedge clk);
    out(0, 1, 0, "R8 cpu asserted");
    wr(1, 32'h200);
    @(negedge clk); @(negedge clk);
    out(0, 0, 0, "R8 cpu released");

    // R9 usb cannot see group 0
    wr(6, 32'hFFFF_FFFF);
    pulse(8'hFF, 0);
    repeat (2) @(negedge clk);
    out(0, 0, 0, "R9 usb ignores endpoints");
    pulse(0, 32'h2000);
    @(negedge clk);
    chk(usb_irq === 1'b1, "R9 usb asserted", {31'b0, usb_irq}, 32'h1);
    wr(6, 32'h0000_2000);
    @(negedge clk);
    chk(usb_irq === 1'b0, "R11 usb master off", {31'b0, usb_irq}, 32'h0);

    // random traffic against the model
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      src_ep = ($urandom % 4 == 0) ? 8'($urandom) : '0;
      src_sys = ($urandom % 4 == 0) ? $urandom : '0;
      reg_wr = ($urandom % 3 == 0);
      reg_addr = 3'($urandom);
      reg_wdata = $urandom;
    end
    @(negedge clk); reg_wr = 0; src_ep = 0; src_sys = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule